// File: doc/BRIEF.md
# Three-Task Supervised Watchdog

This block is a watchdog timer that only software with all of its parts healthy can keep quiet. A free-running up-counter starts at zero and steps once per clock. A magnitude comparator checks it against a programmable limit. When the counter reaches the limit, the block drives a system reset pulse of fixed, parameterised length. The counter then starts again from zero.

Servicing is gated by three alive flags, one for each supervised task. Each task pulses its own strobe to mark that it has run during the current interval, and the flag stays set until the interval ends. A service request clears the counter only if all three flags were already set. A successful service also empties the flags, so every task has to report again before the next service. A service request with a flag missing changes nothing about the counter. The tasks that did not report are recorded on a failure-status output, so one stalled task is enough to let the watchdog expire and to identify itself.

The block needs no enable. It is armed as soon as its reset is released, and it is armed again after every pulse it issues.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_ni` is low, `wdt_rst_o` is 0 and `fail_o` is all zeros. The counter and all alive flags are cleared, and the limit returns to its default.
- R2: With no accepted service, the first cycle in which `wdt_rst_o` is high comes exactly LIMIT+1 clock edges after the counter was at zero. The counter takes the values 0 to LIMIT, and expiry is detected in the cycle that holds LIMIT.
- R3: `wdt_rst_o` stays high for exactly RST_LEN cycles. The counter is held at zero while the pulse lasts and counts up from zero afterwards, so the next pulse follows LIMIT+1 edges after the pulse falls.
- R4: A strobe on `alive_set_i[i]` sets alive flag i from the next cycle onward. The flag then holds until a service is accepted, an expiry occurs or a reset pulse is active. Flags may be set in different cycles.
- R5: A request on `svc_i` is accepted only if all three flags were already set before that cycle. A strobe that arrives in the same cycle as the request does not count. An accepted request clears the counter and all three flags at the same edge, and prevents the reset pulse.
- R6: A request on `svc_i` made while any flag is clear is rejected and leaves the counter running. At the next edge, `fail_o` becomes the set of missing flags: bit i = 1 means task i had not reported.
- R7: An accepted service clears `fail_o` to zero.
- R8: On expiry, `fail_o` takes the set of flags that were clear at that moment.
- R9: If a valid service request arrives in the very cycle in which the counter holds a value at or above the limit, expiry wins and the reset pulse is issued.
- R10: While `wdt_rst_o` is high, alive strobes and service requests are ignored. The flags are emptied, `fail_o` is left unchanged, and a service right after the pulse is rejected with all bits marked missing.
- R11: A pulse on `limit_we_i` loads `limit_i` as the new limit at the next edge. If the counter is already at or above the new limit, expiry happens at the following edge. Later intervals last new-limit+1 edges.
- R12: After reset, the limit equals the DEF_LIMIT parameter. The default of 32767 gives 32768 counts per interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| limit_we_i | input | 1 | Load strobe for a new timeout limit |
| limit_i | input | CNT_W | Timeout limit value, in counts |
| alive_set_i | input | NTASK | One alive strobe for each supervised task |
| svc_i | input | 1 | Service (clear) request |
| wdt_rst_o | output | 1 | System reset pulse, RST_LEN cycles wide |
| fail_o | output | NTASK | Flags of the tasks missing at the last rejected service or expiry |

## Verification
The bench builds the block with CNT_W = 8, DEF_LIMIT = 20 and RST_LEN = 3. With these values one interval lasts 21 cycles and a pulse lasts 3 cycles, so many intervals fit into a short run. The short limit also makes it cheap to line up a service request with the exact expiry cycle, and to lower the limit below the running count. The three-cycle pulse gives room to drive strobes and requests while the pulse is high and to show that they are ignored.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Action taken by the interval timer in the current cycle, in priority order
    typedef enum logic [1:0] {
        ACT_COUNT   = 2'd0,
        ACT_SERVICE = 2'd1,
        ACT_EXPIRE  = 2'd2,
        ACT_HOLD    = 2'd3
    } wdog_act_e;

endpackage

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned DEF_LIMIT = 32767,
    parameter int unsigned RST_LEN   = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             limit_we_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             svc_i,
    input  logic             all_alive_i,
    output wdog_act_e        act_o,
    output logic             pulse_o
);
    localparam int unsigned      PW_W       = $clog2(RST_LEN + 1);
    localparam logic [PW_W-1:0]  PW_INIT    = PW_W'(RST_LEN);
    localparam logic [CNT_W-1:0] LIMIT_INIT = CNT_W'(DEF_LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] limit;
        logic [PW_W-1:0]  pw;
    } tmr_t;

    tmr_t      tmr_d, tmr_q;
    wdog_act_e act;

    always_comb begin
        // priority: active pulse, then expiry, then accepted service
        if (tmr_q.pw != '0) begin
            act = ACT_HOLD;
        end else if (tmr_q.cnt >= tmr_q.limit) begin
            act = ACT_EXPIRE;
        end else if (svc_i && all_alive_i) begin
            act = ACT_SERVICE;
        end else begin
            act = ACT_COUNT;
        end

        tmr_d       = tmr_q;
        tmr_d.limit = limit_we_i ? limit_i : tmr_q.limit;
        unique case (act)
            ACT_HOLD: begin
                tmr_d.cnt = '0;
                tmr_d.pw  = tmr_q.pw - PW_W'(1);
            end
            ACT_EXPIRE: begin
                tmr_d.cnt = '0;
                tmr_d.pw  = PW_INIT;
            end
            ACT_SERVICE: tmr_d.cnt = '0;
            default:     tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '{cnt: '0, limit: LIMIT_INIT, pw: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign act_o   = act;
    assign pulse_o = (tmr_q.pw != '0);

    // R2: a pulse only starts after the count met the limit
    p_rise_on_limit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pulse_o) |-> $past(tmr_q.cnt >= tmr_q.limit));

    // R3: counter is parked at zero through the pulse
    p_hold_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> (tmr_q.cnt == '0));

    // R3: counting resumes from zero once the pulse ends
    p_restart_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pulse_o) |-> (tmr_q.cnt == '0));

    // R5: an accepted service leaves the counter at zero
    p_service_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act == ACT_SERVICE) |=> (tmr_q.cnt == '0) && !pulse_o);

endmodule

// File: rtl/wdog_alive.sv
module wdog_alive
    import wdog_pkg::*;
#(
    parameter int unsigned NTASK = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NTASK-1:0] set_i,
    input  logic             svc_i,
    input  wdog_act_e        act_i,
    output logic             all_alive_o,
    output logic [NTASK-1:0] fail_o
);
    typedef struct packed {
        logic [NTASK-1:0] alive;
        logic [NTASK-1:0] fail;
    } flg_t;

    flg_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        unique case (act_i)
            ACT_HOLD: flg_d.alive = '0;
            ACT_EXPIRE: begin
                flg_d.alive = '0;
                flg_d.fail  = ~flg_q.alive;
            end
            ACT_SERVICE: begin
                flg_d.alive = set_i;
                flg_d.fail  = '0;
            end
            default: begin
                flg_d.alive = flg_q.alive | set_i;
                if (svc_i) begin
                    flg_d.fail = ~flg_q.alive;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign all_alive_o = &flg_q.alive;
    assign fail_o      = flg_q.fail;

    // R4: flags never drop while the timer just counts
    p_flags_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i == ACT_COUNT) |=> ((flg_q.alive & $past(flg_q.alive)) == $past(flg_q.alive)));

    // R6: a rejected request reports a non-empty missing set
    p_reject_marks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i == ACT_COUNT && svc_i) |=> (fail_o == ~$past(flg_q.alive)) && (fail_o != '0));

    // R7: an accepted service clears the failure status
    p_service_clears_fail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i == ACT_SERVICE) |=> (fail_o == '0));

    // R10: the reset pulse empties the flags and freezes the status
    p_hold_empties_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i == ACT_HOLD) |=> (flg_q.alive == '0) && $stable(fail_o));

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int unsigned NTASK     = 3,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned DEF_LIMIT = 32767,
    parameter int unsigned RST_LEN   = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             limit_we_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [NTASK-1:0] alive_set_i,
    input  logic             svc_i,
    output logic             wdt_rst_o,
    output logic [NTASK-1:0] fail_o
);
    wdog_act_e act;
    logic      all_alive;

    wdog_timer #(
        .CNT_W     (CNT_W),
        .DEF_LIMIT (DEF_LIMIT),
        .RST_LEN   (RST_LEN)
    ) u_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .limit_we_i  (limit_we_i),
        .limit_i     (limit_i),
        .svc_i       (svc_i),
        .all_alive_i (all_alive),
        .act_o       (act),
        .pulse_o     (wdt_rst_o)
    );

    wdog_alive #(
        .NTASK (NTASK)
    ) u_alive (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .set_i       (alive_set_i),
        .svc_i       (svc_i),
        .act_i       (act),
        .all_alive_o (all_alive),
        .fail_o      (fail_o)
    );

    // R8: an expiry always leaves a non-empty failure record if a flag was clear
    p_expire_marks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act == ACT_EXPIRE && !all_alive) |=> (fail_o != '0) && wdt_rst_o);

endmodule

// File: tb/wdog_supervisor_tb.sv
`timescale 1ns/1ps
module wdog_supervisor_tb;
    localparam int N    = 3;
    localparam int W    = 8;
    localparam int LIM  = 20;
    localparam int PL   = 3;
    localparam int FULL = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         we;
    logic [W-1:0] lval;
    logic [N-1:0] set;
    logic         svc;
    logic         wdt_rst;
    logic [N-1:0] fail;

    always #2.5 clk = ~clk;

    wdog_supervisor #(
        .NTASK(N), .CNT_W(W), .DEF_LIMIT(LIM), .RST_LEN(PL)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .limit_we_i(we), .limit_i(lval),
        .alive_set_i(set), .svc_i(svc), .wdt_rst_o(wdt_rst), .fail_o(fail)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt, m_limit, m_pw, m_alive, m_fail;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_limit = LIM; m_pw = 0; m_alive = 0; m_fail = 0;
        end else begin
            int nl;
            nl = we ? int'(lval) : m_limit;
            if (m_pw > 0) begin
                m_pw = m_pw - 1; m_cnt = 0; m_alive = 0;
            end else if (m_cnt >= m_limit) begin
                m_fail = ~m_alive & FULL; m_alive = 0; m_cnt = 0; m_pw = PL;
            end else if (svc && m_alive == FULL) begin
                m_cnt = 0; m_alive = int'(set); m_fail = 0;
            end else begin
                if (svc) m_fail = ~m_alive & FULL;
                m_alive = m_alive | int'(set);
                m_cnt = m_cnt + 1;
            end
            m_limit = nl;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        n_cmp++;
        if (wdt_rst !== (m_pw > 0) || int'(fail) != m_fail) begin
            n_bad++;
            $display("FAIL %s: rst=%0b fail=%0d expected rst=%0b fail=%0d",
                     cur_req, wdt_rst, fail, (m_pw > 0), m_fail);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(output int cyc);
        cyc = 0;
        while (!wdt_rst) begin @(negedge clk); cyc++; end
    endtask

    task automatic wait_fall(output int cyc);
        cyc = 0;
        while (wdt_rst) begin @(negedge clk); cyc++; end
    endtask

    task automatic strobe(input logic [N-1:0] s);
        set = s; @(negedge clk); set = '0;
    endtask

    task automatic service;
        svc = 1'b1; @(negedge clk); svc = 1'b0;
    endtask

    initial begin
        int c;
        int rises;
        rst_n = 1'b0; we = 1'b0; lval = '0; set = '0; svc = 1'b0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(wdt_rst == 1'b0, "R1", wdt_rst, 0);
        chk(fail == '0, "R1", fail, 0);

        // R12 / R2: default limit, idle counter
        rst_n = 1'b1;
        cur_req = "R12";
        wait_rise(c);
        chk(c == LIM + 1, "R2", c, LIM + 1);
        chk(fail == 3'b111, "R8", fail, 7);
        cur_req = "R3";
        wait_fall(c);
        chk(c == PL, "R3", c, PL);
        wait_rise(c);
        chk(c == LIM + 1, "R3", c, LIM + 1);
        wait_fall(c);

        // R4 / R5: flags set in separate cycles, regular service
        cur_req = "R4";
        rises = 0;
        for (int k = 0; k < 8; k++) begin
            strobe(3'b001); @(negedge clk);
            strobe(3'b010);
            strobe(3'b100); @(negedge clk);
            cur_req = "R5";
            service;
            repeat (3) begin @(negedge clk); if (wdt_rst) rises++; end
        end
        chk(rises == 0, "R5", rises, 0);
        chk(fail == '0, "R7", fail, 0);

        // R6: one task stalls, request rejected, expiry follows
        cur_req = "R6";
        strobe(3'b001);
        strobe(3'b100);
        service;
        chk(fail == 3'b010, "R6", fail, 2);
        wait_rise(c);
        chk(fail == 3'b010, "R8", fail, 2);
        wait_fall(c);

        // R9: valid service in the expiry cycle loses
        cur_req = "R9";
        strobe(3'b111);
        while (m_cnt != m_limit) @(negedge clk);
        service;
        chk(wdt_rst == 1'b1, "R9", wdt_rst, 1);

        // R10: strobes and requests during the pulse are ignored
        cur_req = "R10";
        set = 3'b111; svc = 1'b1;
        @(negedge clk);
        set = '0; svc = 1'b0;
        wait_fall(c);
        chk(fail == '0, "R10", fail, 0);
        service;
        chk(fail == 3'b111, "R10", fail, 7);

        // R11: lower the limit below the running count
        cur_req = "R11";
        repeat (9) @(negedge clk);
        we = 1'b1; lval = 8'd5;
        @(negedge clk);
        we = 1'b0;
        chk(wdt_rst == 1'b0, "R11", wdt_rst, 0);
        @(negedge clk);
        chk(wdt_rst == 1'b1, "R11", wdt_rst, 1);
        wait_fall(c);
        wait_rise(c);
        chk(c == 6, "R11", c, 6);
        wait_fall(c);
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule